// File: doc/BRIEF.md
# Branch Condition and Restart Vector Unit

This block sits beside the program counter of a small 8-bit processor core and answers two questions. For a conditional jump, call or return, it reports whether the condition selected by a 3-bit code holds against the carry, zero, sign and parity flags. For a restart, it supplies the 16-bit target address. That address is either the software restart slot selected by a 3-bit number, or the fixed vector of the highest-priority hardware interrupt being requested.

The block holds the interrupt-enable flip-flop. It also tells a halted core when an acknowledged interrupt lets it resume. Three maskable request lines and one non-maskable line are examined every cycle.

The condition result, the pending flag and the vector are combinational. The enable state and the wake pulse are registered.

Top module: `branch_vector_unit`

## Requirements
- R1: `cond_taken` follows `cond_code` in the same cycle. The encoding is 0 = Z clear, 1 = Z set, 2 = CY clear, 3 = CY set, 4 = P clear (parity odd), 5 = P set (parity even), 6 = S clear (positive), 7 = S set (minus).
- R2: When no interrupt is pending, `vector_addr` equals `rst_num` times 8, covering 0x0000 to 0x0038.
- R3: When an interrupt is pending, `vector_addr` is the winning source's vector. The non-maskable line uses 0x0024. `irq_lvl[0]` uses 0x002C, `irq_lvl[1]` uses 0x0034 and `irq_lvl[2]` uses 0x003C.
- R4: Among simultaneous eligible requests the winner is chosen in this order: the non-maskable line first, then `irq_lvl[2]`, then `irq_lvl[1]`, then `irq_lvl[0]`.
- R5: A request on `irq_lvl[k]` is eligible only when `int_enabled` is 1 and `irq_mask[k]` is 0. Otherwise it has no effect on `int_pending` or `vector_addr`.
- R6: `irq_trap` makes `int_pending` 1 regardless of `int_enabled` and `irq_mask`.
- R7: `int_enabled` is 0 after reset. `ie_set` sets it at the next edge and `ie_clr` clears it at the next edge; `ie_clr` wins over `ie_set`.
- R8: `int_ack` clears `int_enabled` at the next edge and wins over `ie_set`.
- R9: `halt_release` is 1 for the one cycle after an edge at which `halted`, `int_ack` and `int_pending` were all 1, and is 0 otherwise, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_code | input | 3 | Branch condition selector |
| flag_cy | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_p | input | 1 | Parity flag |
| rst_num | input | 3 | Software restart number |
| irq_trap | input | 1 | Non-maskable interrupt request |
| irq_lvl | input | 3 | Maskable requests, bit 2 highest |
| irq_mask | input | 3 | Mask per maskable request, 1 blocks |
| ie_set | input | 1 | Enable-interrupts strobe |
| ie_clr | input | 1 | Disable-interrupts strobe |
| halted | input | 1 | Core is in the halt state |
| int_ack | input | 1 | Core accepts the pending interrupt |
| cond_taken | output | 1 | Selected condition holds |
| int_pending | output | 1 | An eligible interrupt is requested |
| vector_addr | output | 16 | Restart target address |
| int_enabled | output | 1 | Interrupt-enable flip-flop |
| halt_release | output | 1 | Wake pulse for a halted core |

## Verification
The properties assume that the core raises `int_ack` only as a response, although the block must still clear its enable when it sees a stray acknowledge. They also assume that requests and flags are plain levels that are valid at each rising edge. The stimulus drives every input at the falling edge from a seeded random source. Enable, disable and acknowledge strobes are kept sparse so that long enabled stretches occur, and the mask and request lines cover all values. Directed steps add the cases where only the non-maskable line fires with everything masked or disabled, and where all sources request at once.

// File: rtl/bvu_pkg.sv
package bvu_pkg;
    typedef struct packed {
        logic ie;
        logic wake;
    } bvu_state_t;

    localparam int unsigned COND_W = 3;
endpackage

// File: rtl/bvu_cond_eval.sv
module bvu_cond_eval
    import bvu_pkg::*;
(
    input  logic [COND_W-1:0] code,
    input  logic              cy,
    input  logic              z,
    input  logic              s,
    input  logic              p,
    output logic              taken
);
    logic sel_flag;

    // Upper two bits pick the flag, bit 0 picks the polarity tested.
    always_comb begin
        unique case (code[2:1])
            2'd0:    sel_flag = z;
            2'd1:    sel_flag = cy;
            2'd2:    sel_flag = p;
            default: sel_flag = s;
        endcase
        taken = sel_flag ^ ~code[0];
    end
endmodule

// File: rtl/bvu_irq_prio.sv
module bvu_irq_prio #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned NUM_MASK = 3,
    parameter int unsigned TRAP_VEC = 36,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic                trap,
    input  logic [NUM_MASK-1:0] req,
    input  logic [NUM_MASK-1:0] mask,
    input  logic                ie,
    output logic                pending,
    output logic [ADDR_W-1:0]   vector
);
    logic [NUM_MASK-1:0] eligible;

    genvar g;
    generate
        for (g = 0; g < NUM_MASK; g++) begin : g_elig
            assign eligible[g] = req[g] & ~mask[g] & ie;
        end
    endgenerate

    // Scan upwards so the highest eligible index overrides; trap overrides all.
    always_comb begin
        pending = 1'b0;
        vector  = '0;
        for (int k = 0; k < NUM_MASK; k++) begin
            if (eligible[k]) begin
                pending = 1'b1;
                vector  = ADDR_W'(TRAP_VEC + VEC_STEP * (k + 1));
            end
        end
        if (trap) begin
            pending = 1'b1;
            vector  = ADDR_W'(TRAP_VEC);
        end
    end
endmodule

// File: rtl/branch_vector_unit.sv
module branch_vector_unit
    import bvu_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned NUM_MASK = 3,
    parameter int unsigned RST_W    = 3,
    parameter int unsigned TRAP_VEC = 36,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COND_W-1:0]   cond_code,
    input  logic                flag_cy,
    input  logic                flag_z,
    input  logic                flag_s,
    input  logic                flag_p,
    input  logic [RST_W-1:0]    rst_num,
    input  logic                irq_trap,
    input  logic [NUM_MASK-1:0] irq_lvl,
    input  logic [NUM_MASK-1:0] irq_mask,
    input  logic                ie_set,
    input  logic                ie_clr,
    input  logic                halted,
    input  logic                int_ack,
    output logic                cond_taken,
    output logic                int_pending,
    output logic [ADDR_W-1:0]   vector_addr,
    output logic                int_enabled,
    output logic                halt_release
);
    localparam int unsigned SHIFT = $clog2(VEC_STEP);
    localparam int unsigned PAD_W = ADDR_W - RST_W - SHIFT;

    bvu_state_t st_d, st_q;
    logic [ADDR_W-1:0] hw_vec;
    logic [ADDR_W-1:0] sw_vec;

    bvu_cond_eval i_cond (
        .code  (cond_code),
        .cy    (flag_cy),
        .z     (flag_z),
        .s     (flag_s),
        .p     (flag_p),
        .taken (cond_taken)
    );

    bvu_irq_prio #(
        .ADDR_W   (ADDR_W),
        .NUM_MASK (NUM_MASK),
        .TRAP_VEC (TRAP_VEC),
        .VEC_STEP (VEC_STEP)
    ) i_prio (
        .trap    (irq_trap),
        .req     (irq_lvl),
        .mask    (irq_mask),
        .ie      (st_q.ie),
        .pending (int_pending),
        .vector  (hw_vec)
    );

    assign sw_vec      = {{PAD_W{1'b0}}, rst_num, {SHIFT{1'b0}}};
    assign vector_addr = int_pending ? hw_vec : sw_vec;

    always_comb begin
        st_d = st_q;
        // Acknowledge and disable both dominate enable.
        if (int_ack || ie_clr) begin
            st_d.ie = 1'b0;
        end else if (ie_set) begin
            st_d.ie = 1'b1;
        end
        st_d.wake = halted & int_ack & int_pending;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_enabled  = st_q.ie;
    assign halt_release = st_q.wake;
endmodule

// File: rtl/bvu_checker.sv
module bvu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  cond_code,
    input logic        flag_cy,
    input logic        flag_s,
    input logic        irq_trap,
    input logic [2:0]  irq_lvl,
    input logic [2:0]  irq_mask,
    input logic        ie_set,
    input logic        ie_clr,
    input logic        halted,
    input logic        int_ack,
    input logic        cond_taken,
    input logic        int_pending,
    input logic [15:0] vector_addr,
    input logic        int_enabled,
    input logic        halt_release
);
    a_r1_carry_set: assert property (@(posedge clk) disable iff (!rst_n)
        cond_code == 3'd3 |-> cond_taken == flag_cy);
    a_r1_minus: assert property (@(posedge clk) disable iff (!rst_n)
        cond_code == 3'd7 |-> cond_taken == flag_s);
    a_r6_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_trap |-> int_pending && vector_addr == 16'h0024);
    a_r5_disabled_only_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !int_enabled |-> int_pending == irq_trap);
    a_r4_top_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_trap && int_enabled && irq_lvl[2] && !irq_mask[2]) |-> vector_addr == 16'h003C);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ie_clr |=> !int_enabled);
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_set && !ie_clr && !int_ack) |=> int_enabled);
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !int_enabled);
    a_r9_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        halt_release |-> $past(halted && int_ack && int_pending));
endmodule

bind branch_vector_unit bvu_checker i_bvu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cond_code    (cond_code),
    .flag_cy      (flag_cy),
    .flag_s       (flag_s),
    .irq_trap     (irq_trap),
    .irq_lvl      (irq_lvl),
    .irq_mask     (irq_mask),
    .ie_set       (ie_set),
    .ie_clr       (ie_clr),
    .halted       (halted),
    .int_ack      (int_ack),
    .cond_taken   (cond_taken),
    .int_pending  (int_pending),
    .vector_addr  (vector_addr),
    .int_enabled  (int_enabled),
    .halt_release (halt_release)
);

// File: tb/test_branch_vector_unit.sv
`timescale 1ns/1ps
module test_branch_vector_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cond_code = '0;
    logic        flag_cy = 0, flag_z = 0, flag_s = 0, flag_p = 0;
    logic [2:0]  rst_num = '0;
    logic        irq_trap = 0;
    logic [2:0]  irq_lvl = '0;
    logic [2:0]  irq_mask = '0;
    logic        ie_set = 0, ie_clr = 0, halted = 0, int_ack = 0;
    logic        cond_taken, int_pending, int_enabled, halt_release;
    logic [15:0] vector_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic m_ie = 0;
    logic m_wake = 0;

    always #2 clk = ~clk;

    branch_vector_unit i_branch_vector_unit (
        .clk(clk), .rst_n(rst_n), .cond_code(cond_code),
        .flag_cy(flag_cy), .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p),
        .rst_num(rst_num), .irq_trap(irq_trap), .irq_lvl(irq_lvl),
        .irq_mask(irq_mask), .ie_set(ie_set), .ie_clr(ie_clr),
        .halted(halted), .int_ack(int_ack), .cond_taken(cond_taken),
        .int_pending(int_pending), .vector_addr(vector_addr),
        .int_enabled(int_enabled), .halt_release(halt_release)
    );

    function automatic logic exp_cond(input logic [2:0] c, input logic cy,
                                      input logic z, input logic s, input logic p);
        case (c)
            3'd0: return !z;
            3'd1: return z;
            3'd2: return !cy;
            3'd3: return cy;
            3'd4: return !p;
            3'd5: return p;
            3'd6: return !s;
            default: return s;
        endcase
    endfunction

    function automatic logic exp_pend(input logic ie);
        return irq_trap || (ie && |(irq_lvl & ~irq_mask));
    endfunction

    function automatic logic [15:0] exp_vec(input logic ie);
        if (irq_trap) return 16'h0024;
        if (ie && irq_lvl[2] && !irq_mask[2]) return 16'h003C;
        if (ie && irq_lvl[1] && !irq_mask[1]) return 16'h0034;
        if (ie && irq_lvl[0] && !irq_mask[0]) return 16'h002C;
        return {10'd0, rst_num, 3'b000};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Check the combinational outputs against the model, then advance one edge.
    task automatic step_check();
        #1;
        chk("R1 cond", {15'd0, cond_taken}, {15'd0, exp_cond(cond_code, flag_cy, flag_z, flag_s, flag_p)});
        chk("R5 R6 pending", {15'd0, int_pending}, {15'd0, exp_pend(m_ie)});
        chk("R2 R3 R4 vector", vector_addr, exp_vec(m_ie));
        m_wake = halted && int_ack && exp_pend(m_ie);
        if (int_ack || ie_clr) m_ie = 0;
        else if (ie_set) m_ie = 1;
        @(posedge clk);
        #1;
        chk("R7 R8 enable", {15'd0, int_enabled}, {15'd0, m_ie});
        chk("R9 wake", {15'd0, halt_release}, {15'd0, m_wake});
        @(negedge clk);
    endtask

    task automatic drive(input logic tr, input logic [2:0] lv, input logic [2:0] mk,
                         input logic es, input logic ec, input logic h, input logic ak);
        irq_trap = tr; irq_lvl = lv; irq_mask = mk;
        ie_set = es; ie_clr = ec; halted = h; int_ack = ak;
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1;
        chk("R7 reset enable", {15'd0, int_enabled}, 16'd0);
        chk("R9 reset wake", {15'd0, halt_release}, 16'd0);
        @(negedge clk);
        rst_n = 1;

        // R6: trap alone while disabled and all masked
        drive(1, 3'b111, 3'b111, 0, 0, 0, 0);
        step_check();
        // R7: enable, then R4 with everything requesting
        drive(0, 0, 0, 1, 0, 0, 0);
        step_check();
        drive(1, 3'b111, 3'b000, 0, 0, 0, 0);
        step_check();
        drive(0, 3'b111, 3'b000, 0, 0, 0, 0);
        step_check();
        drive(0, 3'b011, 3'b000, 0, 0, 0, 0);
        step_check();
        // R5: masked level ignored while enabled
        drive(0, 3'b001, 3'b001, 0, 0, 0, 0);
        step_check();
        // R9 and R8: halted core acknowledges level 0
        drive(0, 3'b001, 3'b000, 1, 0, 1, 1);
        step_check();
        // R7: set and clear together, clear wins
        drive(0, 0, 0, 1, 1, 0, 0);
        step_check();
        // R2: every software slot with no request
        for (int n = 0; n < 8; n++) begin
            rst_num = n[2:0];
            cond_code = n[2:0];
            drive(0, 0, 0, 0, 0, 0, 0);
            step_check();
        end

        for (int i = 0; i < 3000; i++) begin
            cond_code = $urandom();
            {flag_cy, flag_z, flag_s, flag_p} = $urandom();
            rst_num = $urandom();
            drive(($urandom() % 8) == 0, $urandom(), $urandom(),
                  ($urandom() % 4) == 0, ($urandom() % 8) == 0,
                  $urandom(), ($urandom() % 8) == 0);
            step_check();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule